// File: doc/BRIEF.md
# Dual-Bank 21-Tap Multiply-Accumulate Filter Array

This block is a 21-tap transversal filter built from three chained sections of seven multiply-accumulate stages. Each section receives its own 8-bit sample stream on every clock, typically the same image line seen through different external line delays, so the array can act as a 21-tap one-dimensional filter or as a 7x3 two-dimensional window. Each section is in transposed form: every stage multiplies the section's present sample by its own coefficient and adds the registered result of the stage above it. One extra register sits between sections. The result leaves through one output register at full precision, with no rounding or truncation.

Two banks of 21 coefficients are held. A small state machine picks the active bank every cycle. In state `BS_FIXED` the active bank follows `cur_bank_i`. When `swap_en_i` is high the machine alternates between `BS_ALT0` (bank 0 active) and `BS_ALT1` (bank 1 active) so that every sample uses the other bank from its predecessor. The transitions are: `BS_FIXED`→`BS_FIXED` when swap is off; `BS_FIXED`→`BS_ALT1` or `BS_ALT0` when swap is on, choosing the bank opposite to the one `cur_bank_i` selected in that cycle; `BS_ALT0`↔`BS_ALT1` while swap stays on; and any alternating state→`BS_FIXED` when swap is off. A host-style write port loads one coefficient per cycle into the bank not in use, so coefficients can be changed without stopping the data.

Top module: `tap21_mac_array`

## Requirements
- R1: Section s (0 first, 2 last) has taps i=0..6, and tap 0 is nearest the section output. A sample on section 2 entering at clock edge k, multiplied by tap i of the bank active at edge k, appears in `sum_o` after edge k+i+1.
- R2: Each hop between sections adds one register. A section-1 sample reaches `sum_o` after edge k+i+9, and a section-0 sample reaches it after edge k+i+17. `sum_o` is the sum of all such terms.
- R3: With `data_uns_i`=1 a sample is read as 0..255. With `data_uns_i`=0 it is read as two's complement, -128..127.
- R4: Each coefficient keeps the format given by `wr_coef_uns_i` at the moment it is written (1: 0..255, 0: -128..127). Coefficients with different formats may sit side by side in one bank.
- R5: With `swap_en_i`=0 the bank selected by `cur_bank_i` supplies all 21 coefficients at that edge. An accepted write takes effect from the following edge.
- R6: With `swap_en_i`=1 the active bank alternates on every edge. The first edge after swap is turned on uses the bank given by `cur_bank_i`.
- R7: A write is ignored, and `wr_err_o` is high for the cycle after it, when `wr_sec_i`>2, when `wr_tap_i`>6, or when swap is off and `wr_bank_i` equals the active bank. Otherwise `wr_err_o` is low.
- R8: `sum_o` is a 22-bit two's complement value with no loss. An all-255 unsigned case gives 1365525, and -128 data times 255 coefficients gives -685440.
- R9: Reset clears both banks to zero, enters `BS_FIXED` and clears the pipeline. `sum_o` and `wr_err_o` read 0 until nonzero coefficients are loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| smp0_i | input | 8 | Sample stream for section 0 (first) |
| smp1_i | input | 8 | Sample stream for section 1 |
| smp2_i | input | 8 | Sample stream for section 2 (last) |
| data_uns_i | input | 1 | 1: samples unsigned, 0: two's complement |
| cur_bank_i | input | 1 | Bank selection when not swapping; first bank when swapping |
| swap_en_i | input | 1 | Alternate banks on every edge |
| wr_en_i | input | 1 | Coefficient write strobe |
| wr_bank_i | input | 1 | Bank addressed by the write |
| wr_sec_i | input | 2 | Section addressed by the write |
| wr_tap_i | input | 3 | Tap addressed by the write, 0 nearest output |
| wr_coef_i | input | 8 | Coefficient value |
| wr_coef_uns_i | input | 1 | Format of this coefficient, 1 unsigned |
| sum_o | output | 22 | Registered filter result, two's complement |
| wr_err_o | output | 1 | Pulse for a rejected write |

## Verification
The hardest situation to reach is a coefficient write that lands while swap mode alternates the banks. In that case the same edge must use the old value and store the new one, and the two banks then differ from one sample to the next. The stimulus enables swap with random data, writes into both banks during the alternation, and then drops swap to return to a fixed bank. This exercises every state transition. A behavioural model keeps a history of samples and of the active coefficients at every edge. From that history it forms the expected sum with the section delays stated in R1 and R2, and it is compared with the design on every clock.

// File: rtl/mac21_pkg.sv
`timescale 1ns/1ps
package mac21_pkg;
    localparam int NSEC  = 3;
    localparam int NTAP  = 7;
    localparam int NCOEF = NSEC * NTAP;
    localparam int SEC_W = $clog2(NSEC);
    localparam int TAP_W = $clog2(NTAP);
    localparam int IDX_W = $clog2(NCOEF + NTAP);

    typedef enum logic [1:0] {
        BS_FIXED = 2'd0,
        BS_ALT0  = 2'd1,
        BS_ALT1  = 2'd2
    } bank_state_t;
endpackage

// File: rtl/mac21_bank_fsm.sv
`timescale 1ns/1ps
module mac21_bank_fsm
    import mac21_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic swap_en_i,
    input  logic cur_bank_i,
    output logic act_bank_o
);
    bank_state_t st_q, st_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= BS_FIXED;
        else        st_q <= st_d;
    end

    always_comb begin
        unique case (st_q)
            BS_FIXED: act_bank_o = cur_bank_i;
            BS_ALT0:  act_bank_o = 1'b0;
            BS_ALT1:  act_bank_o = 1'b1;
            default:  act_bank_o = cur_bank_i;
        endcase
    end

    always_comb begin
        if (!swap_en_i)      st_d = BS_FIXED;
        else if (act_bank_o) st_d = BS_ALT0;
        else                 st_d = BS_ALT1;
    end

    assert_alternate_R6: assert property (@(posedge clk) disable iff (!rst_n)
        swap_en_i |=> (!swap_en_i || act_bank_o != $past(act_bank_o)));

    assert_follow_select_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !swap_en_i |=> act_bank_o == cur_bank_i);
endmodule

// File: rtl/mac21_coef_store.sv
`timescale 1ns/1ps
module mac21_coef_store
    import mac21_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                act_bank_i,
    input  logic                swap_en_i,
    input  logic                wr_en_i,
    input  logic                wr_bank_i,
    input  logic [SEC_W-1:0]    wr_sec_i,
    input  logic [TAP_W-1:0]    wr_tap_i,
    input  logic [DW-1:0]       wr_coef_i,
    input  logic                wr_coef_uns_i,
    output logic signed [DW:0]  coef_o [NCOEF],
    output logic                wr_err_o
);
    logic signed [DW:0] bank_q [2][NCOEF];
    logic               addr_ok, hit_active, accept;
    logic [IDX_W-1:0]   slot;
    logic signed [DW:0] wide_coef;

    assign addr_ok    = (wr_sec_i < SEC_W'(NSEC)) && (wr_tap_i < TAP_W'(NTAP));
    assign hit_active = !swap_en_i && (wr_bank_i == act_bank_i);
    assign accept     = wr_en_i && addr_ok && !hit_active;
    assign slot       = IDX_W'(wr_sec_i) * IDX_W'(NTAP) + IDX_W'(wr_tap_i);
    assign wide_coef  = wr_coef_uns_i ? {1'b0, wr_coef_i} : {wr_coef_i[DW-1], wr_coef_i};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int b = 0; b < 2; b++)
                for (int k = 0; k < NCOEF; k++)
                    bank_q[b][k] <= '0;
            wr_err_o <= 1'b0;
        end else begin
            if (accept) bank_q[wr_bank_i][slot] <= wide_coef;
            wr_err_o <= wr_en_i && !(addr_ok && !hit_active);
        end
    end

    always_comb begin
        for (int k = 0; k < NCOEF; k++)
            coef_o[k] = bank_q[act_bank_i][k];
    end

    assert_reject_active_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && !swap_en_i && wr_bank_i == act_bank_i) |=> wr_err_o);

    assert_err_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_err_o |-> $past(wr_en_i));
endmodule

// File: rtl/mac21_section.sv
`timescale 1ns/1ps
module mac21_section
    import mac21_pkg::*;
#(
    parameter int DW    = 8,
    parameter int ACC_W = 22
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [DW-1:0]           smp_i,
    input  logic                    data_uns_i,
    input  logic signed [DW:0]      coef_i [NTAP],
    input  logic signed [ACC_W-1:0] link_i,
    output logic signed [ACC_W-1:0] sec_o
);
    localparam int OPW = DW + 1;
    localparam int PW  = 2 * OPW;

    logic signed [OPW-1:0]   xs;
    logic signed [ACC_W-1:0] prod  [NTAP];
    logic signed [ACC_W-1:0] nxt   [NTAP];
    logic signed [ACC_W-1:0] acc_q [NTAP];

    assign xs = data_uns_i ? {1'b0, smp_i} : {smp_i[DW-1], smp_i};

    always_comb begin
        for (int i = 0; i < NTAP; i++) begin
            logic signed [PW-1:0] pr;
            pr      = xs * coef_i[i];
            prod[i] = ACC_W'(pr);
        end
    end

    always_comb begin
        for (int i = 0; i < NTAP - 1; i++)
            nxt[i] = acc_q[i+1];
        nxt[NTAP-1] = link_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NTAP; i++) acc_q[i] <= '0;
        end else begin
            for (int i = 0; i < NTAP; i++) acc_q[i] <= prod[i] + nxt[i];
        end
    end

    assign sec_o = acc_q[0];

    assert_quiet_head_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_i == '0 && link_i == '0) |=> acc_q[NTAP-1] == '0);
endmodule

// File: rtl/tap21_mac_array.sv
`timescale 1ns/1ps
module tap21_mac_array
    import mac21_pkg::*;
#(
    parameter int DW    = 8,
    parameter int ACC_W = 22
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [DW-1:0]       smp0_i,
    input  logic [DW-1:0]       smp1_i,
    input  logic [DW-1:0]       smp2_i,
    input  logic                data_uns_i,
    input  logic                cur_bank_i,
    input  logic                swap_en_i,
    input  logic                wr_en_i,
    input  logic                wr_bank_i,
    input  logic [SEC_W-1:0]    wr_sec_i,
    input  logic [TAP_W-1:0]    wr_tap_i,
    input  logic [DW-1:0]       wr_coef_i,
    input  logic                wr_coef_uns_i,
    output logic [ACC_W-1:0]    sum_o,
    output logic                wr_err_o
);
    logic                    act_bank;
    logic signed [DW:0]      coef    [NCOEF];
    logic [DW-1:0]           smp     [NSEC];
    logic signed [ACC_W-1:0] sec_out [NSEC];
    logic signed [ACC_W-1:0] link_in [NSEC];
    logic signed [ACC_W-1:0] link_q  [NSEC-1];
    logic signed [ACC_W-1:0] sum_q;

    always_comb begin
        smp[0] = smp0_i;
        smp[1] = smp1_i;
        smp[2] = smp2_i;
    end

    mac21_bank_fsm i_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .swap_en_i  (swap_en_i),
        .cur_bank_i (cur_bank_i),
        .act_bank_o (act_bank)
    );

    mac21_coef_store #(.DW(DW)) i_store (
        .clk           (clk),
        .rst_n         (rst_n),
        .act_bank_i    (act_bank),
        .swap_en_i     (swap_en_i),
        .wr_en_i       (wr_en_i),
        .wr_bank_i     (wr_bank_i),
        .wr_sec_i      (wr_sec_i),
        .wr_tap_i      (wr_tap_i),
        .wr_coef_i     (wr_coef_i),
        .wr_coef_uns_i (wr_coef_uns_i),
        .coef_o        (coef),
        .wr_err_o      (wr_err_o)
    );

    always_comb begin
        link_in[0] = '0;
        for (int s = 1; s < NSEC; s++) link_in[s] = link_q[s-1];
    end

    generate
        for (genvar s = 0; s < NSEC; s++) begin : g_sec
            logic signed [DW:0] sc [NTAP];
            always_comb begin
                for (int i = 0; i < NTAP; i++) sc[i] = coef[s*NTAP + i];
            end
            mac21_section #(.DW(DW), .ACC_W(ACC_W)) i_sec (
                .clk        (clk),
                .rst_n      (rst_n),
                .smp_i      (smp[s]),
                .data_uns_i (data_uns_i),
                .coef_i     (sc),
                .link_i     (link_in[s]),
                .sec_o      (sec_out[s])
            );
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < NSEC - 1; s++) link_q[s] <= '0;
            sum_q <= '0;
        end else begin
            for (int s = 0; s < NSEC - 1; s++) link_q[s] <= sec_out[s];
            sum_q <= sec_out[NSEC-1];
        end
    end

    assign sum_o = sum_q;

    assert_link_hop_R2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> link_q[0] == $past(sec_out[0]));
endmodule

// File: tb/test_tap21_mac_array.sv
`timescale 1ns/1ps
module test_tap21_mac_array;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [7:0] s0 = '0, s1 = '0, s2 = '0;
    logic duns = 1'b0, cbank = 1'b0, swp = 1'b0;
    logic wen = 1'b0, wbank = 1'b0, wuns = 1'b0;
    logic [1:0] wsec = '0;
    logic [2:0] wtap = '0;
    logic [7:0] wcoef = '0;
    logic [21:0] sum;
    logic err;

    int hx [3][64];
    int hc [64][21];
    int mb [2][21];
    int e = 0;
    bit alt = 0, altb = 0;
    int checks = 0, errors = 0;
    bit done = 0;
    string req = "R9";

    always #10 clk = ~clk;

    tap21_mac_array i_tap21_mac_array (
        .clk(clk), .rst_n(rst_n), .smp0_i(s0), .smp1_i(s1), .smp2_i(s2),
        .data_uns_i(duns), .cur_bank_i(cbank), .swap_en_i(swp),
        .wr_en_i(wen), .wr_bank_i(wbank), .wr_sec_i(wsec), .wr_tap_i(wtap),
        .wr_coef_i(wcoef), .wr_coef_uns_i(wuns), .sum_o(sum), .wr_err_o(err)
    );

    function automatic int ext(logic [7:0] v, logic u);
        return u ? int'(v) : int'($signed(v));
    endfunction

    function automatic int term(int s, int i, int k);
        if (k < 0) return 0;
        return hx[s][k % 64] * hc[k % 64][s*7 + i];
    endfunction

    function automatic int sect(int s, int j);
        int acc = 0;
        for (int i = 0; i < 7; i++) acc += term(s, i, j - i);
        return acc;
    endfunction

    task automatic check(bit ok, string what, int act, int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    task automatic tick();
        int expy, experr, act;
        bit okw;
        @(posedge clk);
        act = alt ? int'(altb) : int'(cbank);
        hx[0][e % 64] = ext(s0, duns);
        hx[1][e % 64] = ext(s1, duns);
        hx[2][e % 64] = ext(s2, duns);
        for (int k = 0; k < 21; k++) hc[e % 64][k] = mb[act][k];
        experr = 0;
        if (wen) begin
            okw = (wsec < 3) && (wtap < 7) && !(!swp && int'(wbank) == act);
            if (okw) mb[wbank][int'(wsec)*7 + int'(wtap)] = ext(wcoef, wuns);
            else experr = 1;
        end
        alt = swp;
        if (swp) altb = (act == 0);
        expy = sect(2, e - 1) + sect(1, e - 9) + sect(0, e - 17);
        e++;
        @(negedge clk);
        check(int'($signed(sum)) == expy, "sum_o", int'($signed(sum)), expy);
        check(int'(err) == experr, "wr_err_o", int'(err), experr);
    endtask

    task automatic wr(logic b, int sec, int tap, logic [7:0] v, logic u);
        wen = 1'b1; wbank = b; wsec = 2'(sec); wtap = 3'(tap); wcoef = v; wuns = u;
        tick();
        wen = 1'b0;
    endtask

    task automatic run_rand(int n);
        for (int c = 0; c < n; c++) begin
            s0 = 8'($urandom); s1 = 8'($urandom); s2 = 8'($urandom);
            tick();
        end
    endtask

    task automatic run_hold(int n);
        for (int c = 0; c < n; c++) tick();
    endtask

    initial begin
        for (int b = 0; b < 2; b++) for (int k = 0; k < 21; k++) mb[b][k] = 0;
        for (int k = 0; k < 64; k++) begin
            for (int s = 0; s < 3; s++) hx[s][k] = 0;
            for (int j = 0; j < 21; j++) hc[k][j] = 0;
        end
        repeat (3) @(negedge clk);
        req = "R9";
        check(sum == '0, "sum_o in reset", int'(sum), 0);
        check(err == 1'b0, "wr_err_o in reset", int'(err), 0);
        rst_n = 1'b1;
        s0 = 8'd100; s1 = 8'd100; s2 = 8'd100;
        run_hold(25);

        req = "R7";
        wr(1'b0, 0, 0, 8'd5, 1'b0);
        wr(1'b1, 3, 0, 8'd5, 1'b0);
        wr(1'b1, 0, 7, 8'd5, 1'b0);
        run_hold(25);

        req = "R1";
        s0 = '0; s1 = '0; s2 = '0;
        for (int k = 0; k < 21; k++) wr(1'b1, k / 7, k % 7, 8'(k + 1), 1'b0);
        cbank = 1'b1;
        run_hold(20);
        s2 = 8'd1; tick(); s2 = '0; run_hold(12);

        req = "R2";
        s1 = 8'd1; tick(); s1 = '0; run_hold(20);
        s0 = 8'd1; tick(); s0 = '0; run_hold(30);

        req = "R3";
        duns = 1'b0; s0 = 8'hFF; s1 = 8'h80; s2 = 8'hFE; run_hold(25);
        duns = 1'b1; run_hold(25);
        duns = 1'b0; run_rand(30);
        duns = 1'b1; run_rand(30);

        req = "R4";
        for (int k = 0; k < 21; k++) wr(1'b0, k / 7, k % 7, 8'hFF, 1'(k % 2));
        cbank = 1'b0;
        run_rand(30);

        req = "R5";
        for (int c = 0; c < 8; c++) begin
            cbank = ~cbank;
            wr(~cbank, c % 3, c % 7, 8'(37 * c + 11), 1'(c % 2));
            run_rand(4);
        end

        req = "R8";
        cbank = 1'b0;
        for (int k = 0; k < 21; k++) wr(1'b1, k / 7, k % 7, 8'hFF, 1'b1);
        cbank = 1'b1; duns = 1'b1;
        s0 = 8'hFF; s1 = 8'hFF; s2 = 8'hFF; run_hold(30);
        check(int'($signed(sum)) == 1365525, "sum_o max", int'($signed(sum)), 1365525);
        duns = 1'b0; s0 = 8'h80; s1 = 8'h80; s2 = 8'h80; run_hold(30);
        check(int'($signed(sum)) == -685440, "sum_o min", int'($signed(sum)), -685440);

        req = "R6";
        cbank = 1'b0; swp = 1'b1;
        run_rand(10);
        wr(1'b0, 1, 2, 8'h9C, 1'b0);
        wr(1'b1, 2, 5, 8'h41, 1'b1);
        run_rand(20);
        swp = 1'b0; run_rand(20);
        cbank = 1'b1; swp = 1'b1; run_rand(20);
        swp = 1'b0; run_rand(20);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 20);
        if (!done) begin
            errors++;
            $display("FAIL %s watchdog: actual hung expected finish", req);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule